// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

A four-bit up-counter whose state bits all change on the same rising clock edge. It can be preset from a data bus, cleared, held or advanced. A compile-time parameter sets the counting modulus, either decade (0 to 9) or full binary (0 to 15). A second parameter sets whether the clear acts at once or waits for the next clock edge.

Two count enables are provided. The counter advances only when both are high. Only the second enable, the carry-gating one, also qualifies the carry output. The carry output goes high while that enable is high and the count sits at its terminal value. Wiring each stage's carry into the carry-gating enable of the next stage, with the first enable shared by all stages, builds a wider synchronous counter without any extra logic between stages.

Top module: `presettable_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0, whatever the clock and the other inputs are doing.
- R2: When clr_ni, load_ni, en_p_i and en_t_i are all high (clr_ni and load_ni inactive, both enables active), each rising edge raises count_o by one. All four bits change on that same edge.
- R3: A counting edge taken from the terminal count returns count_o to 0. The terminal count is 9 when MODULUS is 10 and 15 when MODULUS is 16. With MODULUS 10, a counting edge taken from a loaded value of 10 to 15 also gives 0.
- R4: With clr_ni high and load_ni low, the next rising edge copies data_i into count_o, whatever the levels of en_p_i and en_t_i.
- R5: With ASYNC_CLR 0, a low clr_ni makes count_o 0 at the next rising edge. This takes priority over load and both enables, and count_o does not change before that edge.
- R6: With ASYNC_CLR 1, a low clr_ni makes count_o 0 at once, without waiting for a clock edge. count_o stays 0 while clr_ni is low.
- R7: With clr_ni and load_ni high and en_p_i or en_t_i low, count_o keeps its value across the edge.
- R8: carry_o is combinational. It equals en_t_i AND (count_o == terminal count). en_p_i has no effect on it.
- R9: Three MODULUS-10 stages can be chained. Each stage's carry_o drives the next stage's en_t_i, and en_p_i is shared by all stages. The chain then counts 000 to 999 in decimal and wraps to 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; state changes on the rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset to 0 |
| clr_ni | input | 1 | Active-low clear; acts at once or on the next edge, depending on ASYNC_CLR |
| load_ni | input | 1 | Active-low parallel load |
| data_i | input | WIDTH | Preset value |
| en_p_i | input | 1 | Count enable that does not gate the carry |
| en_t_i | input | 1 | Count enable that also gates carry_o |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal-count carry, gated by en_t_i |

## Verification
A decade instance with synchronous clear and a binary instance with immediate clear receive the same inputs. This shows how the modulus and the clear timing change the result of one input sequence. Directed steps cover loads with both enables low, loads of out-of-range values in the decade instance, and holds with each enable low alone at the terminal count. The last of these separates the carry gating of en_t_i from the count gating of en_p_i. Random cycles mix clears, loads, holds and counts so that the priority order is also tested in its less common combinations. A three-stage decade chain driven by a random enable and occasional clears is checked against a decimal reference, which exercises the carry handoff at every digit rollover.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  cnt_op_e op;

  // priority: clear, load, count, hold
  always_comb begin
    if (!clr_ni)                op = OP_CLEAR;
    else if (!load_ni)          op = OP_LOAD;
    else if (en_p_i && en_t_i)  op = OP_COUNT;
    else                        op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = data_i;
      // at or beyond the last value the count wraps, which also recovers illegal states
      OP_COUNT: nxt_o = (cur_i >= LAST) ? '0 : cur_i + 1'b1;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             en_t_i,
  output logic             carry_o
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  assign carry_o = en_t_i && (cur_i == LAST);
endmodule

// File: rtl/presettable_counter.sv
module presettable_counter #(
  parameter int WIDTH     = 4,
  parameter int MODULUS   = 10,
  parameter bit ASYNC_CLR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             en_p_i,
  input  logic             en_t_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  typedef logic [WIDTH-1:0] cnt_t;
  localparam cnt_t LAST = cnt_t'(MODULUS - 1);

  cnt_t cnt_q;
  cnt_t cnt_d;
  logic clr_sync_n;

  // an immediate clear is applied by the register, so the next-state path never sees it
  assign clr_sync_n = ASYNC_CLR ? 1'b1 : clr_ni;

  cnt_next #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_next (
    .cur_i   (cnt_q),
    .clr_ni  (clr_sync_n),
    .load_ni (load_ni),
    .data_i  (data_i),
    .en_p_i  (en_p_i),
    .en_t_i  (en_t_i),
    .nxt_o   (cnt_d)
  );

  cnt_carry #(.WIDTH(WIDTH), .MODULUS(MODULUS)) u_carry (
    .cur_i   (cnt_q),
    .en_t_i  (en_t_i),
    .carry_o (carry_o)
  );

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
        if (!rst_ni)      cnt_q <= '0;
        else if (!clr_ni) cnt_q <= '0;
        else              cnt_q <= cnt_d;
      end
    end else begin : g_sync_clr
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
      end
    end
  endgenerate

  assign count_o = cnt_q;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_p_i && en_t_i && count_o < LAST)
      |=> (count_o == cnt_t'($past(count_o) + 1'b1)) || !clr_ni);

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_p_i && en_t_i && count_o >= LAST) |=> (count_o == '0));

  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> (count_o == $past(data_i)) || !clr_ni);

  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> (count_o == '0));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o) || !clr_ni);

  a_r8_carry_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> en_t_i);

  a_r8_carry_at_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> (count_o == LAST));
endmodule

// File: tb/presettable_counter_test.sv
`timescale 1ns/100ps
module presettable_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_n = 1'b1, ld_n = 1'b1, p = 1'b0, t = 1'b0;
  logic [3:0] d = 4'd0;
  logic [3:0] q_dec, q_bin;
  logic       co_dec, co_bin;

  logic       c_en = 1'b0, c_clr_n = 1'b1;
  logic [3:0] c_q [3];
  logic       c_co [3];
  logic       c_t [3];

  int n_tests = 0, n_fail = 0;
  int m_dec = 0, m_bin = 0, c_ref = 0;

  always #2 clk = ~clk;

  presettable_counter #(.WIDTH(4), .MODULUS(10), .ASYNC_CLR(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(ld_n), .data_i(d),
    .en_p_i(p), .en_t_i(t), .count_o(q_dec), .carry_o(co_dec));

  presettable_counter #(.WIDTH(4), .MODULUS(16), .ASYNC_CLR(1'b1)) u_bin (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(ld_n), .data_i(d),
    .en_p_i(p), .en_t_i(t), .count_o(q_bin), .carry_o(co_bin));

  for (genvar k = 0; k < 3; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign c_t[k] = c_en;
    end else begin : g_rest
      assign c_t[k] = c_co[k-1];
    end
    presettable_counter #(.WIDTH(4), .MODULUS(10), .ASYNC_CLR(1'b0)) u_stage (
      .clk_i(clk), .rst_ni(rst_n), .clr_ni(c_clr_n), .load_ni(1'b1), .data_i(4'd0),
      .en_p_i(c_en), .en_t_i(c_t[k]), .count_o(c_q[k]), .carry_o(c_co[k]));
  end

  function automatic int model_next(int cur, int modv, bit cn, bit ln, int dv, bit pv, bit tv);
    if (!cn) return 0;
    if (!ln) return dv;
    if (pv && tv) return (cur >= modv - 1) ? 0 : cur + 1;
    return cur;
  endfunction

  function automatic bit model_carry(int cur, int modv, bit tv);
    return tv && (cur == modv - 1);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // called just after a rising edge; applies inputs for one cycle and checks the results
  task automatic step(string tag, bit cn, bit ln, int dv, bit pv, bit tv);
    clr_n = cn; ld_n = ln; d = 4'(dv); p = pv; t = tv;
    #0.5;
    check("R8", "dec carry", int'(co_dec), int'(model_carry(m_dec, 10, tv)));
    if (cn) check("R8", "bin carry", int'(co_bin), int'(model_carry(m_bin, 16, tv)));
    if (!cn) begin
      check("R6", "bin immediate clear", int'(q_bin), 0);
      check("R5", "dec waits for edge", int'(q_dec), m_dec);
      m_bin = 0;
    end
    @(posedge clk); #1;
    m_dec = model_next(m_dec, 10, cn, ln, dv, pv, tv);
    m_bin = model_next(m_bin, 16, cn, ln, dv, pv, tv);
    if (!c_clr_n) c_ref = 0;
    else if (c_en) c_ref = (c_ref + 1) % 1000;
    check(tag, "dec count", int'(q_dec), m_dec);
    check(tag, "bin count", int'(q_bin), m_bin);
    check("R9", "chain value", int'(c_q[2]) * 100 + int'(c_q[1]) * 10 + int'(c_q[0]), c_ref);
  endtask

  initial begin
    #(4 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c47));
    #1;
    check("R1", "dec reset", int'(q_dec), 0);
    check("R1", "bin reset", int'(q_bin), 0);
    p = 1'b1; t = 1'b1; ld_n = 1'b0; d = 4'd7;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "dec held in reset", int'(q_dec), 0);
    check("R1", "chain reset", int'(c_q[0]), 0);
    rst_n = 1'b1;

    step("R4", 1, 0, 12, 0, 0);   // load with both enables low
    step("R3", 1, 1, 0, 1, 1);    // dec 12 -> 0, bin 12 -> 13
    step("R2", 1, 1, 0, 1, 1);
    step("R4", 1, 0, 9, 1, 1);    // load beats count
    step("R7", 1, 1, 0, 0, 1);    // P low: hold at 9, carry high
    step("R7", 1, 1, 0, 1, 0);    // T low: hold, carry low
    step("R3", 1, 1, 0, 1, 1);    // dec 9 -> 0
    step("R4", 1, 0, 15, 0, 1);
    step("R3", 1, 1, 0, 1, 1);    // bin 15 -> 0, dec 15 -> 0
    step("R4", 1, 0, 5, 1, 1);
    step("R5", 0, 0, 11, 1, 1);   // clear beats load
    step("R2", 1, 1, 0, 1, 1);

    for (int i = 0; i < 2500; i++) begin
      bit cn, ln, pv, tv;
      int dv;
      cn = ($urandom % 20) != 0;
      ln = ($urandom % 8) != 0;
      dv = $urandom % 16;
      pv = ($urandom % 4) != 0;
      tv = ($urandom % 4) != 0;
      c_en = ($urandom % 5) != 0;
      c_clr_n = ($urandom % 300) != 0;
      if (!cn)            step("R5", cn, ln, dv, pv, tv);
      else if (!ln)       step("R4", cn, ln, dv, pv, tv);
      else if (pv && tv)  step("R2", cn, ln, dv, pv, tv);
      else                step("R7", cn, ln, dv, pv, tv);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule